// File: doc/BRIEF.md
# Multi-Context Program Counter File

This block replaces the lone program counter of a compact 16-bit processor front end with a small file of counters, one for each hardware context. A context can be a software thread or an address stream for direct memory access. All contexts share one address path. In each cycle the block presents the counter of the active context as the fetch address. When a fetch is taken, only that entry advances, or it takes a branch or jump target.

After each fetch, a round-robin scheduler moves on to the next enabled context. It holds the current context while the decoder reports that an interlocked sequence is still open. Two kinds of sequence count as open: an immediate prefix waiting for the instruction that consumes it, and a condition-code producer waiting for the branch that reads it. The block also derives the link register that a call of the active thread must write, so that threads sharing one register file keep separate return addresses.

Top module: `pc_ctx_file`

## Requirements
- R1: After reset every counter is zero, context 0 is active, and only context 0 is enabled. So fetch_addr is 0, ctx_idx is 0 and link_idx is 15.
- R2: A clock edge with fetch_valid high and load_valid low adds one to the active context's counter, wrapping from 16'hFFFF to 0.
- R3: A clock edge with load_valid high writes load_target into the active context's counter, whether or not fetch_valid is high. The load takes precedence over the increment, and every other counter keeps its value.
- R4: After a fetch edge with interlock_busy low, the active context becomes the next enabled context in ascending index order after the current one. The search wraps from 15 to 0 and skips disabled contexts. If only the current context is enabled, it stays active.
- R5: After a fetch edge with interlock_busy high, the active context does not change.
- R6: An edge with fetch_valid low and load_valid low changes neither the active context nor any counter.
- R7: An edge with en_we high replaces the enable mask with en_wdata, where bit i enables context i. The new mask governs fetches from the next edge on. If no context is enabled, the active context stays where it is.
- R8: link_idx equals 15 minus twice the two low bits of ctx_idx. This gives 15, 13, 11 and 9 for threads 0 to 3, and the values repeat for higher indices.
- R9: fetch_addr always shows the counter of the context that ctx_idx names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | A fetch from fetch_addr is taken this cycle |
| interlock_busy | input | 1 | An interlocked instruction sequence is open, so hold the context |
| load_valid | input | 1 | Branch or jump: load the active counter |
| load_target | input | 16 | Branch or jump target address |
| en_we | input | 1 | Write strobe for the context enable mask |
| en_wdata | input | 16 | New enable mask, one bit for each context |
| fetch_addr | output | 16 | Counter of the active context |
| ctx_idx | output | 4 | Index of the active context |
| link_idx | output | 4 | Register index a call must use for its return address |

## Verification
The bench drives several stimulus patterns.
- A single enabled context shows that the counter increments and wraps, with no switching.
- A sparse enable mask shows that the scheduler skips disabled contexts and wraps from 15 to 0.
- A fully enabled mask walks every index, which covers each link register value.
- Fetches under interlock_busy separate holding the context from advancing it.
- Loads made while other contexts are parked show that the target reaches only the active counter. Those parked counters are then read back when the scheduler returns to them.
- An empty mask, idle cycles, and a long stretch of mixed random stimulus probe the remaining interactions between load, increment, enable writes and the interlock hold.

// File: rtl/pc_ctx_pkg.sv
package pc_ctx_pkg;
   localparam int unsigned DEF_ADDR_W       = 16;
   localparam int unsigned DEF_NUM_CTX      = 16;
   localparam int unsigned DEF_REG_CNT      = 16;
   localparam int unsigned DEF_LINK_BASE    = 15;
   localparam int unsigned DEF_LINK_THREADS = 4;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pc_ctx_store.sv
module pc_ctx_store #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned NUM_CTX = 16,
   parameter int unsigned IDX_W   = $clog2(NUM_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  sel,
   input  logic              inc,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   output logic [ADDR_W-1:0] rd
);
   logic [ADDR_W-1:0] pc_q [NUM_CTX];

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_entry
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q[g] <= '0;
         end else if (sel == MY_IDX) begin
            if (ld) begin
               pc_q[g] <= ld_val;
            end else if (inc) begin
               pc_q[g] <= pc_q[g] + ADDR_W'(1);
            end
         end
      end
   end

   assign rd = pc_q[sel];
endmodule

// File: rtl/pc_ctx_sched.sv
module pc_ctx_sched #(
   parameter int unsigned NUM_CTX = 16,
   parameter int unsigned IDX_W   = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   input  logic               en_we,
   input  logic [NUM_CTX-1:0] en_wdata,
   output logic [IDX_W-1:0]   cur
);
   localparam logic [NUM_CTX-1:0] EN_RESET = NUM_CTX'(1);

   logic [NUM_CTX-1:0] en_q;
   logic [IDX_W-1:0]   cur_q;
   logic [IDX_W-1:0]   nxt;
   logic [IDX_W-1:0]   cand;
   logic               found;

   always_comb begin
      nxt   = cur_q;
      found = 1'b0;
      cand  = cur_q;
      for (int k = 1; k <= NUM_CTX; k++) begin
         cand = cur_q + IDX_W'(k);
         if (!found && en_q[cand]) begin
            nxt   = cand;
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= EN_RESET;
         cur_q <= '0;
      end else begin
         if (en_we) begin
            en_q <= en_wdata;
         end
         if (advance) begin
            cur_q <= nxt;
         end
      end
   end

   assign cur = cur_q;
endmodule

// File: rtl/pc_ctx_link.sv
module pc_ctx_link #(
   parameter int unsigned IDX_W        = 4,
   parameter int unsigned RIDX_W       = 4,
   parameter int unsigned LINK_BASE    = 15,
   parameter int unsigned LINK_THREADS = 4
) (
   input  logic [IDX_W-1:0]  ctx,
   output logic [RIDX_W-1:0] link
);
   if (LINK_THREADS == 1) begin : g_fixed
      logic unused_ctx;
      assign unused_ctx = ^ctx;
      assign link = RIDX_W'(LINK_BASE);
   end else begin : g_spread
      localparam int unsigned TW = $clog2(LINK_THREADS);
      logic [TW-1:0] thr;
      logic          unused_hi;
      assign thr  = ctx[TW-1:0];
      assign link = RIDX_W'(LINK_BASE) - RIDX_W'({thr, 1'b0});
      if (IDX_W > TW) begin : g_hi
         assign unused_hi = ^ctx[IDX_W-1:TW];
      end else begin : g_nohi
         assign unused_hi = 1'b0;
      end
   end
endmodule

// File: rtl/pc_ctx_file.sv
module pc_ctx_file
   import pc_ctx_pkg::*;
#(
   parameter int unsigned ADDR_W       = DEF_ADDR_W,
   parameter int unsigned NUM_CTX      = DEF_NUM_CTX,
   parameter int unsigned REG_CNT      = DEF_REG_CNT,
   parameter int unsigned LINK_BASE    = DEF_LINK_BASE,
   parameter int unsigned LINK_THREADS = DEF_LINK_THREADS,
   localparam int unsigned IDX_W       = $clog2(NUM_CTX),
   localparam int unsigned RIDX_W      = $clog2(REG_CNT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fetch_valid,
   input  logic               interlock_busy,
   input  logic               load_valid,
   input  logic [ADDR_W-1:0]  load_target,
   input  logic               en_we,
   input  logic [NUM_CTX-1:0] en_wdata,
   output logic [ADDR_W-1:0]  fetch_addr,
   output logic [IDX_W-1:0]   ctx_idx,
   output logic [RIDX_W-1:0]  link_idx
);
   if (!is_pow2(NUM_CTX) || NUM_CTX < 2) begin : g_bad_ctx
      $error("NUM_CTX must be a power of two of at least 2");
   end
   if (!is_pow2(LINK_THREADS) || LINK_THREADS > NUM_CTX) begin : g_bad_thr
      $error("LINK_THREADS must be a power of two no larger than NUM_CTX");
   end
   if (LINK_BASE >= REG_CNT || LINK_BASE < 2 * (LINK_THREADS - 1)) begin : g_bad_link
      $error("LINK_BASE must leave room for every thread link register");
   end

   logic advance;
   assign advance = fetch_valid & ~interlock_busy;

   pc_ctx_sched #(
      .NUM_CTX (NUM_CTX),
      .IDX_W   (IDX_W)
   ) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (advance),
      .en_we    (en_we),
      .en_wdata (en_wdata),
      .cur      (ctx_idx)
   );

   pc_ctx_store #(
      .ADDR_W  (ADDR_W),
      .NUM_CTX (NUM_CTX),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (ctx_idx),
      .inc    (fetch_valid),
      .ld     (load_valid),
      .ld_val (load_target),
      .rd     (fetch_addr)
   );

   pc_ctx_link #(
      .IDX_W        (IDX_W),
      .RIDX_W       (RIDX_W),
      .LINK_BASE    (LINK_BASE),
      .LINK_THREADS (LINK_THREADS)
   ) u_link (
      .ctx  (ctx_idx),
      .link (link_idx)
   );
endmodule

// File: rtl/pc_ctx_chk.sv
module pc_ctx_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic              interlock_busy,
   input logic              load_valid,
   input logic [ADDR_W-1:0] load_target,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic [IDX_W-1:0]  ctx_idx
);
   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctx_idx == '0) && (fetch_addr == '0)); // R1

   AST_INC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && interlock_busy && !load_valid)
      |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1)); // R2

   AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && (interlock_busy || !fetch_valid))
      |=> fetch_addr == $past(load_target)); // R3

   AST_HOLD_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && interlock_busy) |=> $stable(ctx_idx)); // R5

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && !load_valid) |=> $stable(ctx_idx) && $stable(fetch_addr)); // R6
endmodule

bind pc_ctx_file pc_ctx_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fetch_valid    (fetch_valid),
   .interlock_busy (interlock_busy),
   .load_valid     (load_valid),
   .load_target    (load_target),
   .fetch_addr     (fetch_addr),
   .ctx_idx        (ctx_idx)
);

// File: tb/tb_pc_ctx_file.sv
module tb_pc_ctx_file;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic        interlock_busy = 1'b0;
   logic        load_valid = 1'b0;
   logic [15:0] load_target = '0;
   logic        en_we = 1'b0;
   logic [15:0] en_wdata = '0;
   logic [15:0] fetch_addr;
   logic [3:0]  ctx_idx;
   logic [3:0]  link_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   int unsigned m_pc [16];
   int          m_cur;
   bit [15:0]   m_en;

   always #5 clk = ~clk;

   pc_ctx_file dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .fetch_valid    (fetch_valid),
      .interlock_busy (interlock_busy),
      .load_valid     (load_valid),
      .load_target    (load_target),
      .en_we          (en_we),
      .en_wdata       (en_wdata),
      .fetch_addr     (fetch_addr),
      .ctx_idx        (ctx_idx),
      .link_idx       (link_idx)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) m_pc[i] = 0;
      m_cur = 0;
      m_en  = 16'h0001;
   endtask

   // compare, drive one cycle of inputs, advance the model, wait one clock
   task automatic step(input bit fv, input bit busy, input bit lv, input int unsigned lt,
                       input bit we, input bit [15:0] wd, input string tag);
      int nxt;
      bit found;
      cmp(tag, "ctx_idx", int'(ctx_idx), m_cur);
      cmp(tag, "fetch_addr", int'(fetch_addr), int'(m_pc[m_cur]));            // R9
      cmp("R8", "link_idx", int'(link_idx), 15 - 2 * (m_cur % 4));
      fetch_valid    = fv;
      interlock_busy = busy;
      load_valid     = lv;
      load_target    = lt[15:0];
      en_we          = we;
      en_wdata       = wd;
      if (lv) m_pc[m_cur] = lt & 16'hFFFF;
      else if (fv) m_pc[m_cur] = (m_pc[m_cur] + 1) & 16'hFFFF;
      if (fv && !busy) begin
         nxt = m_cur;
         found = 1'b0;
         for (int k = 1; k <= 16; k++) begin
            if (!found && m_en[(m_cur + k) % 16]) begin
               nxt = (m_cur + k) % 16;
               found = 1'b1;
            end
         end
         m_cur = nxt;
      end
      if (we) m_en = wd;
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 16'h0, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL ALL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      repeat (2) idle("R1");
      cmp("R1", "fetch_addr", int'(fetch_addr), 0);
      cmp("R1", "link_idx", int'(link_idx), 15);

      // R2: single enabled context increments without switching
      repeat (5) step(1, 0, 0, 0, 0, 16'h0, "R2");
      // R3 + R2 wrap: load near top then increment through wrap
      step(0, 0, 1, 16'hFFFE, 0, 16'h0, "R3");
      repeat (3) step(1, 0, 0, 0, 0, 16'h0, "R2");
      cmp("R2", "wrapped addr", int'(fetch_addr), 1);

      // R7 + R4: sparse mask, round robin with skip and wrap
      step(0, 0, 0, 0, 1, 16'b1010_0000_0010_0101, "R7");
      repeat (12) step(1, 0, 0, 0, 0, 16'h0, "R4");

      // R5: held under interlock
      repeat (4) step(1, 1, 0, 0, 0, 16'h0, "R5");
      step(1, 1, 1, 16'h1234, 0, 16'h0, "R5");
      step(1, 0, 0, 0, 0, 16'h0, "R5");

      // R3: loads land only in the active context, others read back later
      step(1, 0, 1, 16'hA000, 0, 16'h0, "R3");
      step(1, 0, 1, 16'hB000, 0, 16'h0, "R3");
      repeat (8) step(1, 0, 0, 0, 0, 16'h0, "R3");

      // R6: idle cycles
      repeat (4) idle("R6");

      // R8: full mask walks every context
      step(0, 0, 0, 0, 1, 16'hFFFF, "R7");
      repeat (34) step(1, 0, 0, 0, 0, 16'h0, "R8");

      // R7: empty mask keeps context, only-current mask keeps context
      step(0, 0, 0, 0, 1, 16'h0000, "R7");
      repeat (3) step(1, 0, 0, 0, 0, 16'h0, "R7");
      step(0, 0, 0, 0, 1, 16'h0001 << ctx_idx, "R7");
      repeat (3) step(1, 0, 0, 0, 0, 16'h0, "R4");

      // mixed random stimulus
      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
              $urandom, $urandom_range(0, 15) == 0, 16'($urandom), "R4");
      end
      idle("R6");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule